// File: doc/BRIEF.md
# Register-list transfer sequencer

This block carries out a multi-register transfer between a register file and memory. It handles four kinds of transfer: a descending stack push, an ascending stack pop, and an ascending block store and block load. A decoder supplies the kind of transfer, an 8-bit register list, a flag that adds one extra register, a base value and a start strobe. The sequencer then makes one 32-bit word access per accepted memory handshake. For stores it reads the register file, and for loads it writes the register file. When it finishes it pulses done and presents the final base value, with a write-enable that says whether that value must be written back.

The extra-register flag applies only to stack transfers. On a push it adds the link register (index 14), which is stored first and therefore at the highest address. On a pop it adds the program counter (index 15), which is loaded last and always receives an even value. On block transfers the flag is ignored. The base value is the stack pointer for stack transfers, or the content of the low register named on `baseReg` for block transfers.

Top module: `reglist_xfer`

## Requirements
- R1: Push (`mode`=0) accesses only the listed registers, plus the link register (index 14) when `extraReg`=1. It starts at `baseVal`-4, steps down by 4, and visits the link register first and then the registers from r7 down to r0. Every access is a store (`memWe`=1) of `rfRdData` for the index on `rfRdIdx`.
- R2: At the end of a non-empty push, `baseWe`=1 and `baseOut` equals the lowest address stored, which is `baseVal`-4×(number of words).
- R3: Pop (`mode`=1) loads from `baseVal` upward in steps of 4. It visits r0 up to r7 and then, when `extraReg`=1, loads one more word into index 15 with bit 0 forced to 0. Each load writes `memRdata` to `rfWrIdx` with `rfWe`=1 in the cycle the access is acknowledged.
- R4: At the end of a non-empty pop, `baseWe`=1 and `baseOut` equals `baseVal`+4×(number of words).
- R5: Block store (`mode`=2) stores the listed registers in ascending order from `baseVal`, ignores `extraReg`, and always ends with `baseWe`=1 and `baseOut`=`baseVal`+4×(number of words).
- R6: Block load (`mode`=3) loads the listed registers in ascending order from `baseVal` and ignores `extraReg`. It ends with `baseWe`=1 and `baseOut`=`baseVal`+4×(number of words) only when list bit `baseReg` is 0; when that bit is 1, `baseWe`=0.
- R7: An access holds `memReq`, `memAddr`, `memWe` and the register index steady until `memAck` is sampled high. Each access takes (wait cycles + 1) cycles.
- R8: `done` is high for exactly one cycle: the cycle after the last access is acknowledged. For N words that is N×(wait+1)+1 cycles after the start edge. `baseWe` is only high together with `done`.
- R9: When no word is to be moved (empty list, and no extra register applies), `done` rises in the cycle after start with no memory request and `baseWe`=0.
- R10: A start strobe, or a change of the list and mode inputs, while a transfer is in progress has no effect on that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| mode | input | 2 | 0 push, 1 pop, 2 block store, 3 block load |
| regList | input | 8 | One bit per register r0..r7 |
| extraReg | input | 1 | Add link register (push) or program counter (pop) |
| baseReg | input | 3 | Index of the base register for block load |
| baseVal | input | 32 | Starting base value |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = store, 0 = load |
| memAddr | output | 32 | Word address of the access |
| memWdata | output | 32 | Store data |
| memAck | input | 1 | Access accepted this cycle |
| memRdata | input | 32 | Load data, valid with memAck |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data |
| rfWe | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |
| baseWe | output | 1 | Write back baseOut (with done) |
| baseOut | output | 32 | Final base value (with done) |

## Verification
The transfer is tried with sparse lists, full lists, single-bit lists and empty lists, in every mode, with and without the extra register. The sparse lists show the visiting order and the skipping of clear bits. The full and single-bit lists show the address stepping at both ends of the register range. Acknowledge delays of zero to three cycles separate handshake holding from plain stepping. A block load whose base sits in the list, a block store and empty transfer with the extra flag set, and a start strobe during a running pop separate the writeback and ignore rules from the common path.

// File: rtl/reglist_pkg.sv
package reglist_pkg;
  localparam int REG_IDX_W = 4;
  localparam int LINK_IDX  = 14;
  localparam int PC_IDX    = 15;

  typedef enum logic [1:0] {
    MODE_PUSH = 2'd0,
    MODE_POP  = 2'd1,
    MODE_STM  = 2'd2,
    MODE_LDM  = 2'd3
  } xferMode_e;

  typedef struct packed {
    logic load;    // latch operands this cycle
    logic step;    // current access accepted, advance
    logic active;  // access in progress
    logic finish;  // completion cycle
  } seqCtl_t;
endpackage

// File: rtl/reglist_ctl.sv
module reglist_ctl
  import reglist_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    startEmpty,
  input  logic    lastSlot,
  input  logic    memAck,
  output seqCtl_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_DONE} state_e;
  state_e state, nextState;

  always_comb begin
    ctl       = '0;
    nextState = state;
    case (state)
      S_IDLE: if (start) begin
        ctl.load  = 1'b1;
        nextState = startEmpty ? S_DONE : S_BUSY;
      end
      S_BUSY: begin
        ctl.active = 1'b1;
        if (memAck) begin
          ctl.step = 1'b1;
          if (lastSlot) nextState = S_DONE;
        end
      end
      S_DONE: begin
        ctl.finish = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/reglist_dp.sv
module reglist_dp
  import reglist_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIST_W = 8,
  localparam int BASE_W = $clog2(LIST_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtl_t              ctl,
  input  logic [1:0]           mode,
  input  logic [LIST_W-1:0]    regList,
  input  logic                 extraReg,
  input  logic [BASE_W-1:0]    baseReg,
  input  logic [DATA_W-1:0]    baseVal,
  input  logic [DATA_W-1:0]    memRdata,
  input  logic [DATA_W-1:0]    rfRdData,
  output logic                 startEmpty,
  output logic                 lastSlot,
  output logic [DATA_W-1:0]    memAddr,
  output logic                 memWe,
  output logic [DATA_W-1:0]    memWdata,
  output logic [REG_IDX_W-1:0] curIdx,
  output logic                 rfWe,
  output logic [DATA_W-1:0]    rfWrData,
  output logic                 baseWe,
  output logic [DATA_W-1:0]    baseOut
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(DATA_W / 8);

  logic [LIST_W:0]     pending;   // top bit: extra register
  logic [LIST_W:0]     selMask;
  logic [DATA_W-1:0]   addr;
  xferMode_e           modeR;
  logic                emptyR;
  logic                baseHitR;
  logic                extraOk;
  logic                isPushR;

  assign extraOk    = extraReg && (xferMode_e'(mode) == MODE_PUSH || xferMode_e'(mode) == MODE_POP);
  assign startEmpty = (regList == '0) && !extraOk;
  assign isPushR    = (modeR == MODE_PUSH);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      addr     <= '0;
      modeR    <= MODE_PUSH;
      emptyR   <= 1'b0;
      baseHitR <= 1'b0;
    end else if (ctl.load) begin
      pending  <= {extraOk, regList};
      addr     <= (xferMode_e'(mode) == MODE_PUSH) ? baseVal - STEP : baseVal;
      modeR    <= xferMode_e'(mode);
      emptyR   <= startEmpty;
      baseHitR <= regList[baseReg];
    end else if (ctl.step) begin
      pending  <= pending & ~selMask;
      addr     <= isPushR ? addr - STEP : addr + STEP;
    end
  end

  // Pick the register for the current access.
  always_comb begin
    selMask = '0;
    curIdx  = '0;
    if (isPushR) begin
      if (pending[LIST_W]) begin
        selMask[LIST_W] = 1'b1;
        curIdx          = REG_IDX_W'(LINK_IDX);
      end else begin
        for (int i = 0; i < LIST_W; i++) begin
          if (pending[i]) begin  // last hit wins: highest index
            selMask = (LIST_W + 1)'(1) << i;
            curIdx  = REG_IDX_W'(i);
          end
        end
      end
    end else begin
      if (pending[LIST_W-1:0] == '0 && pending[LIST_W]) begin
        selMask[LIST_W] = 1'b1;
        curIdx          = REG_IDX_W'(PC_IDX);
      end else begin
        for (int i = LIST_W - 1; i >= 0; i--) begin
          if (pending[i]) begin  // last hit wins: lowest index
            selMask = (LIST_W + 1)'(1) << i;
            curIdx  = REG_IDX_W'(i);
          end
        end
      end
    end
  end

  assign lastSlot = ((pending & (pending - 1'b1)) == '0);
  assign memAddr  = addr;
  assign memWe    = isPushR || (modeR == MODE_STM);
  assign memWdata = rfRdData;
  assign rfWe     = ctl.step && !memWe;
  assign rfWrData = (curIdx == REG_IDX_W'(PC_IDX)) ? {memRdata[DATA_W-1:1], 1'b0} : memRdata;
  assign baseOut  = isPushR ? addr + STEP : addr;
  assign baseWe   = ctl.finish && !emptyR && !((modeR == MODE_LDM) && baseHitR);
endmodule

// File: rtl/reglist_xfer.sv
module reglist_xfer
  import reglist_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LIST_W = 8,
  localparam int BASE_W = $clog2(LIST_W)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [1:0]           mode,
  input  logic [LIST_W-1:0]    regList,
  input  logic                 extraReg,
  input  logic [BASE_W-1:0]    baseReg,
  input  logic [DATA_W-1:0]    baseVal,
  output logic                 memReq,
  output logic                 memWe,
  output logic [DATA_W-1:0]    memAddr,
  output logic [DATA_W-1:0]    memWdata,
  input  logic                 memAck,
  input  logic [DATA_W-1:0]    memRdata,
  output logic [REG_IDX_W-1:0] rfRdIdx,
  input  logic [DATA_W-1:0]    rfRdData,
  output logic                 rfWe,
  output logic [REG_IDX_W-1:0] rfWrIdx,
  output logic [DATA_W-1:0]    rfWrData,
  output logic                 done,
  output logic                 baseWe,
  output logic [DATA_W-1:0]    baseOut
);
  seqCtl_t              ctl;
  logic                 startEmpty;
  logic                 lastSlot;
  logic [REG_IDX_W-1:0] curIdx;

  reglist_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .startEmpty(startEmpty),
    .lastSlot  (lastSlot),
    .memAck    (memAck),
    .ctl       (ctl)
  );

  reglist_dp #(.DATA_W(DATA_W), .LIST_W(LIST_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .mode      (mode),
    .regList   (regList),
    .extraReg  (extraReg),
    .baseReg   (baseReg),
    .baseVal   (baseVal),
    .memRdata  (memRdata),
    .rfRdData  (rfRdData),
    .startEmpty(startEmpty),
    .lastSlot  (lastSlot),
    .memAddr   (memAddr),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .curIdx    (curIdx),
    .rfWe      (rfWe),
    .rfWrData  (rfWrData),
    .baseWe    (baseWe),
    .baseOut   (baseOut)
  );

  assign memReq  = ctl.active;
  assign done    = ctl.finish;
  assign rfRdIdx = curIdx;
  assign rfWrIdx = curIdx;
endmodule

// File: rtl/reglist_xfer_chk.sv
module reglist_xfer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memAck,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [3:0]  rfRdIdx,
  input logic        rfWe,
  input logic [3:0]  rfWrIdx,
  input logic [31:0] rfWrData,
  input logic        done,
  input logic        baseWe
);
  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memAck |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(rfRdIdx));

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memAck |=> !memReq || (memAddr == $past(memAddr) + 32'd4) || (memAddr == $past(memAddr) - 32'd4));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq && !rfWe);

  // R8
  base_we_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWe |-> done);

  // R3
  pc_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe && rfWrIdx == 4'd15 |-> !rfWrData[0]);

  // R3
  load_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    rfWe |-> memReq && memAck && !memWe);
endmodule

bind reglist_xfer reglist_xfer_chk u_chk (.*);

// File: tb/reglist_xfer_bench.sv
module reglist_xfer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  regList = 8'd0;
  logic        extraReg = 1'b0;
  logic [2:0]  baseReg = 3'd0;
  logic [31:0] baseVal = 32'd0;
  logic        memReq, memWe, memAck;
  logic [31:0] memAddr, memWdata, memRdata;
  logic [3:0]  rfRdIdx, rfWrIdx;
  logic [31:0] rfRdData, rfWrData;
  logic        rfWe, done, baseWe;
  logic [31:0] baseOut;

  always #2 clk = ~clk;

  reglist_xfer u_reglist_xfer (.*);

  logic [31:0] rf  [16];
  logic [31:0] mem [64];
  logic [31:0] logAddr [16];
  logic [3:0]  logIdx  [16];
  logic        logWe   [16];
  int logN = 0;
  int latency = 0;
  int waitCnt = 0;
  int checks = 0;
  int failures = 0;

  assign rfRdData = rf[rfRdIdx];

  always @(posedge clk) begin
    if (memReq && memAck) begin
      if (logN < 16) begin
        logAddr[logN] = memAddr;
        logIdx[logN]  = rfRdIdx;
        logWe[logN]   = memWe;
      end
      logN = logN + 1;
      waitCnt = 0;
      if (memWe) mem[memAddr[7:2]] <= memWdata;
    end else if (memReq) begin
      waitCnt = waitCnt + 1;
    end
    if (rfWe) rf[rfWrIdx] <= rfWrData;
  end

  always @(negedge clk) begin
    memAck   = memReq && (waitCnt >= latency);
    memRdata = mem[memAddr[7:2]];
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic initState();
    for (int i = 0; i < 16; i++) rf[i] = 32'hC0DE_0000 + 32'(i);
    for (int k = 0; k < 64; k++) mem[k] = 32'h5A00_0001 + 32'(k << 8);
  endtask

  task automatic runOp(input logic [1:0] md, input logic [7:0] lst, input logic ext,
                       input logic [2:0] br, input logic [31:0] bs, input int lat,
                       input bit poke, input string tag);
    logic [31:0] expAddr [16];
    logic [3:0]  expIdx  [16];
    logic [31:0] memSnap [64];
    int expN;
    int cycles;
    logic [31:0] a;
    logic [31:0] finalBase;
    logic gotWe;
    logic [31:0] gotBase;
    bit expStore, expBaseWe, extraUsed;
    initState();
    for (int k = 0; k < 64; k++) memSnap[k] = mem[k];
    latency = lat;
    @(negedge clk);
    logN = 0;
    mode = md; regList = lst; extraReg = ext; baseReg = br; baseVal = bs; start = 1'b1;
    cycles = 0; gotWe = 1'b0; gotBase = '0;
    forever begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      start = poke && (cycles == 1);
      if (poke && cycles == 1) begin
        mode = 2'd3; regList = 8'hFF; baseVal = 32'h0; extraReg = 1'b1;
      end
      if (done) begin
        gotWe = baseWe; gotBase = baseOut;
        break;
      end
      if (cycles > 500) break;
    end
    // expected behaviour from the requirements
    extraUsed = ext && (md < 2);
    expStore  = (md == 2'd0) || (md == 2'd2);
    expN = 0;
    if (md == 2'd0) begin
      a = bs - 32'd4;
      if (extraUsed) begin expAddr[expN] = a; expIdx[expN] = 4'd14; expN++; a -= 32'd4; end
      for (int i = 7; i >= 0; i--)
        if (lst[i]) begin expAddr[expN] = a; expIdx[expN] = 4'(i); expN++; a -= 32'd4; end
      finalBase = a + 32'd4;
    end else begin
      a = bs;
      for (int i = 0; i < 8; i++)
        if (lst[i]) begin expAddr[expN] = a; expIdx[expN] = 4'(i); expN++; a += 32'd4; end
      if (extraUsed) begin expAddr[expN] = a; expIdx[expN] = 4'd15; expN++; a += 32'd4; end
      finalBase = a;
    end
    expBaseWe = (expN > 0) && !((md == 2'd3) && lst[br]);

    check(cycles <= 500, tag, "completion", 32'(cycles), 32'(expN * (lat + 1) + 1));
    check(logN == expN, tag, "access count", 32'(logN), 32'(expN));
    for (int j = 0; j < expN && j < logN; j++) begin
      check(logAddr[j] == expAddr[j], tag, "access address", logAddr[j], expAddr[j]);
      check(logIdx[j] == expIdx[j], tag, "access register", 32'(logIdx[j]), 32'(expIdx[j]));
      check(logWe[j] == expStore, tag, "access direction", 32'(logWe[j]), 32'(expStore));
    end
    // R8 timing
    check(cycles == expN * (lat + 1) + 1, "R8", "done cycle", 32'(cycles), 32'(expN * (lat + 1) + 1));
    check(gotWe == expBaseWe, tag, "base write enable", 32'(gotWe), 32'(expBaseWe));
    if (expBaseWe) check(gotBase == finalBase, tag, "final base", gotBase, finalBase);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R8", "done after pulse", 32'(done), 32'd0);
    for (int j = 0; j < expN; j++) begin
      if (expStore) begin
        check(mem[expAddr[j][7:2]] == 32'hC0DE_0000 + 32'(expIdx[j]), tag, "stored word",
              mem[expAddr[j][7:2]], 32'hC0DE_0000 + 32'(expIdx[j]));
      end else if (expIdx[j] == 4'd15) begin
        check(rf[15] == (memSnap[expAddr[j][7:2]] & 32'hFFFF_FFFE), tag, "pc load",
              rf[15], memSnap[expAddr[j][7:2]] & 32'hFFFF_FFFE);
      end else begin
        check(rf[expIdx[j]] == memSnap[expAddr[j][7:2]], tag, "loaded word",
              rf[expIdx[j]], memSnap[expAddr[j][7:2]]);
      end
    end
  endtask

  function automatic string tagOf(input logic [1:0] md);
    case (md)
      2'd0:    return "R1 R2";
      2'd1:    return "R3 R4";
      2'd2:    return "R5";
      default: return "R6";
    endcase
  endfunction

  // {mode[2], list[8], extra[1], baseReg[3], base[32], wait[2]}
  localparam logic [47:0] VEC [8] = '{
    {2'd0, 8'b1010_0101, 1'b1, 3'd0, 32'h0000_0080, 2'd0},
    {2'd0, 8'hFF,        1'b0, 3'd0, 32'h0000_00C0, 2'd1},
    {2'd1, 8'b0110_0011, 1'b1, 3'd0, 32'h0000_0040, 2'd0},
    {2'd1, 8'h80,        1'b0, 3'd0, 32'h0000_0010, 2'd2},
    {2'd2, 8'b0001_1110, 1'b0, 3'd5, 32'h0000_0020, 2'd0},
    {2'd3, 8'b1100_0001, 1'b0, 3'd3, 32'h0000_0030, 2'd1},
    {2'd0, 8'h00,        1'b1, 3'd0, 32'h0000_0100, 2'd0},
    {2'd1, 8'h00,        1'b1, 3'd0, 32'h0000_0070, 2'd3}
  };

  initial begin
    #(4 * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    initState();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!done && !memReq && !rfWe && !baseWe, "R8", "reset state",
          {28'd0, done, memReq, rfWe, baseWe}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!memReq && !done, "R9", "idle after reset", {30'd0, memReq, done}, 32'd0);

    for (int v = 0; v < 8; v++)
      runOp(VEC[v][47:46], VEC[v][45:38], VEC[v][37], VEC[v][36:34], VEC[v][33:2],
            int'(VEC[v][1:0]), 1'b0, tagOf(VEC[v][47:46]));

    // R6: base in list, no writeback
    runOp(2'd3, 8'b0010_1100, 1'b0, 3'd2, 32'h0000_0050, 0, 1'b0, "R6");
    // R5: extra flag ignored on block store
    runOp(2'd2, 8'h81, 1'b1, 3'd1, 32'h0000_0060, 0, 1'b0, "R5");
    // R9: empty push, and empty block load with extra flag set
    runOp(2'd0, 8'h00, 1'b0, 3'd0, 32'h0000_0080, 0, 1'b0, "R9");
    runOp(2'd3, 8'h00, 1'b1, 3'd0, 32'h0000_0040, 0, 1'b0, "R9");
    // R7: long acknowledge delay
    runOp(2'd2, 8'b0100_1001, 1'b0, 3'd0, 32'h0000_0090, 3, 1'b0, "R7");
    // R10: start and new operands mid-transfer are ignored
    runOp(2'd1, 8'h0F, 1'b0, 3'd0, 32'h0000_0020, 1, 1'b1, "R10");
    repeat (4) @(negedge clk);
    check(!memReq && !done, "R10", "no second transfer", {30'd0, memReq, done}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule